// File: doc/BRIEF.md
# SDRAM Write Burst Column Sequencer

This block is the device-side write path control of a single-data-rate SDRAM. It watches the command pins on every rising clock edge and, when a WRITE arrives, drives the array's write port with a strobe, a bank number and a column. The first word of a burst goes in on the very edge that registers the WRITE. Each later word goes in on the following edges at the next column. Fixed bursts step through an aligned block of columns and wrap inside it. A full-page burst walks the whole page, wraps to column 0 and carries on until a new command stops it.

A new WRITE on any cycle takes over the data path at once, with no gap and no alignment rule. A burst-terminate command stops the current burst. When the WRITE requested auto precharge and its burst runs to its natural end, the block raises a one-cycle precharge request with the bank number. The controller is built around two named states. `ST_IDLE` means no burst is open. `ST_BURST` means that words remain to be written. The transitions are: IDLE→BURST on a WRITE whose burst is longer than one word. BURST→BURST on a continuing word or on a new WRITE. BURST→IDLE on the last word, on a terminate, or on any cycle with no word written while the clock is enabled. IDLE→IDLE otherwise. While CKE is low, both states hold.

Top module: `sdram_wr_burst_seq`

## Requirements
- R1: A WRITE (CKE high, CS# low, RAS# high, CAS# low, WE# low) writes its first word in the same cycle: `arr_we` and `data_accept` are high, `arr_col` equals addr[8:0] and `arr_bank` equals `ba`.
- R2: The burst length is taken from `burst_mode` at the WRITE, with 0=1, 1=2, 2=4 and 3=8 words. Each later word is written on the next cycle at column `(start & ~(L-1)) | ((start+i) & (L-1))`, in the same bank.
- R3: After the last word of a fixed burst, `arr_we` stays low until the next WRITE.
- R4: `burst_mode` 7 selects full page. The column counts up modulo 512, wrapping from 511 to 0, and the burst does not end by itself.
- R5: A WRITE issued during a burst writes its own column and bank in that cycle and then continues as its own burst.
- R6: If addr[10] was high at the WRITE, `ap_req` is high for exactly the one cycle after the burst's last word, with `ap_bank` set to that burst's bank.
- R7: A burst cut short by a new WRITE or by a terminate never raises `ap_req`.
- R8: A terminate command (CS# low, RAS# high, CAS# high, WE# low) writes nothing in its cycle and ends the burst.
- R9: `burst_mode` values 4, 5 and 6 behave as one-word bursts.
- R10: While CKE is low, nothing is written, commands are ignored and the burst position is held. The burst resumes at the held column once CKE is high again.
- R11: After reset, with no command, `arr_we` and `ap_req` are low.
- R12: Pin patterns other than WRITE and terminate, including the WRITE pattern with CS# high, write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank address |
| addr | input | ADDR_W | Address; low COL_W bits give the column, bit AP_BIT enables auto precharge |
| burst_mode | input | 3 | Burst length code from the mode register |
| arr_we | output | 1 | Array write strobe for the current cycle |
| arr_bank | output | BANK_W | Bank being written |
| arr_col | output | COL_W | Column being written |
| data_accept | output | 1 | The DQ word is taken this cycle |
| ap_req | output | 1 | One-cycle auto-precharge request |
| ap_bank | output | BANK_W | Bank to precharge |

## Verification
Every fixed length is swept over the start columns at both ends of the page, across all banks and with auto precharge both on and off. This separates wrapping inside the aligned block from plain counting, and it shows whether the precharge pulse lands on the right cycle. Full-page runs that start near column 511, plus one run through the whole page, show the wrap to 0 and the absence of a natural end. Truncation by a new WRITE, termination, CKE stalls, deselected or non-write pin patterns and the reserved length codes each get their own sequence. These sequences tell apart the cases of taking over, stopping, holding and ignoring.

// File: rtl/wrseq_pkg.sv
package wrseq_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } wr_state_t;

    localparam int LEN_W = 4;

    // Fixed burst lengths; unused codes fall back to a single word.
    function automatic logic [LEN_W-1:0] burst_words(input logic [2:0] mode);
        logic [LEN_W-1:0] w;
        case (mode)
            3'd1:    w = 4'd2;
            3'd2:    w = 4'd4;
            3'd3:    w = 4'd8;
            default: w = 4'd1;
        endcase
        return w;
    endfunction

    function automatic logic is_full_page(input logic [2:0] mode);
        return mode == 3'd7;
    endfunction

endpackage

// File: rtl/wrseq_cmd_dec.sv
module wrseq_cmd_dec (
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic is_write,
    output logic is_term
);
    assign is_write = cke & ~cs_n & ras_n & ~cas_n & ~we_n;
    assign is_term  = cke & ~cs_n & ras_n &  cas_n & ~we_n;
endmodule

// File: rtl/wrseq_col_step.sv
module wrseq_col_step #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] col,
    input  logic [COL_W-1:0] mask,
    output logic [COL_W-1:0] nxt
);
    logic [COL_W-1:0] inc;
    assign inc = col + COL_W'(1);
    // Bits above the mask stay put, bits inside it count and wrap.
    assign nxt = (col & ~mask) | (inc & mask);
endmodule

// File: rtl/sdram_wr_burst_seq.sv
module sdram_wr_burst_seq
    import wrseq_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        burst_mode,
    output logic              arr_we,
    output logic [BANK_W-1:0] arr_bank,
    output logic [COL_W-1:0]  arr_col,
    output logic              data_accept,
    output logic              ap_req,
    output logic [BANK_W-1:0] ap_bank
);

    wr_state_t         state_q, state_d;
    logic [COL_W-1:0]  col_q, col_d, mask_q, mask_d;
    logic [BANK_W-1:0] bank_q, bank_d;
    logic [LEN_W-1:0]  rem_q, rem_d;
    logic              full_q, full_d, ap_q, ap_d;
    logic              ap_req_q, ap_req_d;
    logic [BANK_W-1:0] ap_bank_q, ap_bank_d;

    logic              is_write, is_term;
    logic              cur_wr, cur_full, cur_ap, cur_last;
    logic [COL_W-1:0]  cur_col, cur_mask, nxt_col;
    logic [BANK_W-1:0] cur_bank;
    logic [LEN_W-1:0]  cur_rem;

    wrseq_cmd_dec u_dec (
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .is_write (is_write),
        .is_term  (is_term)
    );

    wrseq_col_step #(.COL_W(COL_W)) u_step (
        .col  (cur_col),
        .mask (cur_mask),
        .nxt  (nxt_col)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            col_q     <= '0;
            mask_q    <= '0;
            bank_q    <= '0;
            rem_q     <= '0;
            full_q    <= 1'b0;
            ap_q      <= 1'b0;
            ap_req_q  <= 1'b0;
            ap_bank_q <= '0;
        end else begin
            state_q   <= state_d;
            col_q     <= col_d;
            mask_q    <= mask_d;
            bank_q    <= bank_d;
            rem_q     <= rem_d;
            full_q    <= full_d;
            ap_q      <= ap_d;
            ap_req_q  <= ap_req_d;
            ap_bank_q <= ap_bank_d;
        end
    end

    // Outputs: what is written this cycle
    always_comb begin
        cur_wr   = 1'b0;
        cur_col  = col_q;
        cur_bank = bank_q;
        cur_mask = mask_q;
        cur_rem  = rem_q;
        cur_full = full_q;
        cur_ap   = ap_q;
        if (is_write) begin
            cur_wr   = 1'b1;
            cur_col  = addr[COL_W-1:0];
            cur_bank = ba;
            cur_full = is_full_page(burst_mode);
            cur_rem  = burst_words(burst_mode);
            cur_mask = cur_full ? '1 : COL_W'(burst_words(burst_mode) - LEN_W'(1));
            cur_ap   = addr[AP_BIT];
        end else begin
            unique case (state_q)
                ST_IDLE:  cur_wr = 1'b0;
                ST_BURST: cur_wr = cke & ~is_term;
            endcase
        end
        cur_last = cur_wr & ~cur_full & (cur_rem == LEN_W'(1));
    end

    // Next state
    always_comb begin
        state_d   = state_q;
        col_d     = col_q;
        mask_d    = mask_q;
        bank_d    = bank_q;
        rem_d     = rem_q;
        full_d    = full_q;
        ap_d      = ap_q;
        ap_req_d  = 1'b0;
        ap_bank_d = ap_bank_q;
        if (cke) begin
            if (cur_wr && !cur_last) begin
                state_d = ST_BURST;
                col_d   = nxt_col;
                mask_d  = cur_mask;
                bank_d  = cur_bank;
                rem_d   = cur_rem - LEN_W'(1);
                full_d  = cur_full;
                ap_d    = cur_ap;
            end else begin
                state_d = ST_IDLE;
            end
            ap_req_d  = cur_last & cur_ap;
            ap_bank_d = cur_bank;
        end
    end

    assign arr_we      = cur_wr;
    assign data_accept = cur_wr;
    assign arr_col     = cur_col;
    assign arr_bank    = cur_bank;
    assign ap_req      = ap_req_q;
    assign ap_bank     = ap_bank_q;

    // The first word lands with the command
    p_first_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        is_write |-> (arr_we && arr_col == addr[COL_W-1:0] && arr_bank == ba));

    // A burst that is not finished keeps writing the same bank unless stopped
    p_burst_continues_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !cur_last && cke) |=>
        (!cke || is_write || is_term || (arr_we && arr_bank == $past(arr_bank))));

    // After the last word, only a new WRITE writes
    p_quiet_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && cur_last && cke) |=> (arr_we == is_write));

    // A precharge request always follows a written word
    p_ap_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req |-> $past(arr_we && cke));

    // Terminate writes nothing
    p_term_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_term |-> !arr_we);

    // Clock suspend writes nothing and holds position
    p_cke_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(col_q) && $stable(state_q)));

    p_cke_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !arr_we);

endmodule

// File: tb/sdram_wr_burst_seq_tb.sv
module sdram_wr_burst_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [11:0] addr = '0;
    logic [2:0] burst_mode = '0;
    logic       arr_we, data_accept, ap_req;
    logic [1:0] arr_bank, ap_bank;
    logic [8:0] arr_col;

    int checks = 0;
    int bad    = 0;

    always #2 clk = ~clk;

    sdram_wr_burst_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .burst_mode(burst_mode),
        .arr_we(arr_we), .arr_bank(arr_bank), .arr_col(arr_col),
        .data_accept(data_accept), .ap_req(ap_req), .ap_bank(ap_bank)
    );

    // 0 NOP, 1 WRITE, 2 TERMINATE, 3 WRITE pattern deselected, 4 READ pattern
    task automatic set_cmd(input int c);
        case (c)
            1:       begin cs_n = 0; ras_n = 1; cas_n = 0; we_n = 0; end
            2:       begin cs_n = 0; ras_n = 1; cas_n = 1; we_n = 0; end
            3:       begin cs_n = 1; ras_n = 1; cas_n = 0; we_n = 0; end
            4:       begin cs_n = 0; ras_n = 1; cas_n = 0; we_n = 1; end
            default: begin cs_n = 0; ras_n = 1; cas_n = 1; we_n = 1; end
        endcase
    endtask

    task automatic wr_cmd(input int mode, input int col, input int bank, input bit ap);
        set_cmd(1);
        burst_mode = 3'(mode);
        ba   = 2'(bank);
        addr = 12'(col) | (ap ? 12'h400 : 12'h000);
    endtask

    task automatic chk(input string rq, input bit e_we, input int e_col, input int e_bank,
                       input bit e_ap, input int e_apb);
        bit ok;
        checks++;
        ok = (arr_we == e_we) && (data_accept == e_we) && (ap_req == e_ap);
        if (e_we && (arr_col != 9'(e_col) || arr_bank != 2'(e_bank))) ok = 0;
        if (e_ap && ap_bank != 2'(e_apb)) ok = 0;
        if (!ok) begin
            bad++;
            $display("FAIL %s: we=%0b col=%0d bank=%0d ap=%0b apb=%0d expected we=%0b col=%0d bank=%0d ap=%0b apb=%0d",
                     rq, arr_we, arr_col, arr_bank, ap_req, ap_bank,
                     e_we, e_col, e_bank, e_ap, e_apb);
        end
    endtask

    function automatic int exp_len(input int mode);
        return (mode < 4) ? (1 << mode) : 1;
    endfunction

    // Fixed burst followed by idle cycles (R1, R2, R3, R6, R9)
    task automatic run_fixed(input int mode, input int start, input int bank, input bit ap);
        int len = exp_len(mode);
        for (int i = 0; i <= len + 1; i++) begin
            string tag;
            int ecol;
            @(negedge clk);
            if (i == 0) wr_cmd(mode, start, bank, ap); else set_cmd(0);
            #1;
            ecol = ((start & ~(len - 1)) | ((start + i) & (len - 1))) & 511;
            if (mode >= 4)              tag = "R9";
            else if (i == 0)            tag = "R1";
            else if (i < len)           tag = "R2";
            else if (i == len && ap)    tag = "R6";
            else                        tag = "R3";
            chk(tag, i < len, ecol, bank, ap && (i == len), bank);
        end
    endtask

    // Full-page burst stopped by terminate (R4, R8, R7)
    task automatic run_full(input int start, input int n, input int bank, input bit ap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) wr_cmd(7, start, bank, ap); else set_cmd(0);
            #1;
            chk(i == 0 ? "R1" : "R4", 1'b1, (start + i) % 512, bank, 1'b0, 0);
        end
        @(negedge clk); set_cmd(2); #1;
        chk("R8", 1'b0, 0, 0, 1'b0, 0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); set_cmd(0); #1;
            chk("R7", 1'b0, 0, 0, 1'b0, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        set_cmd(0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1; chk("R11", 1'b0, 0, 0, 1'b0, 0);
        @(negedge clk); #1; chk("R11", 1'b0, 0, 0, 1'b0, 0);

        // Fixed lengths swept over page start and end, all banks, AP on/off
        for (int mode = 0; mode < 4; mode++)
            for (int s = 0; s < 28; s++)
                for (int ap = 0; ap < 2; ap++) begin
                    int start = (s < 16) ? s : 484 + s;
                    run_fixed(mode, start, start % 4, ap[0]);
                end

        // Reserved codes
        for (int mode = 4; mode < 7; mode++) begin
            run_fixed(mode, 13, 1, 1'b1);
            run_fixed(mode, 6, 2, 1'b0);
        end

        // Full page near the end of the page and across the whole page
        for (int s = 508; s < 512; s++) run_full(s, 6, s % 4, 1'b1);
        run_full(0, 514, 3, 1'b1);

        // Truncation by a new WRITE (R5, R7)
        @(negedge clk); wr_cmd(3, 3, 1, 1'b1); #1; chk("R1", 1, 3, 1, 0, 0);
        @(negedge clk); set_cmd(0); #1;          chk("R2", 1, 4, 1, 0, 0);
        @(negedge clk); wr_cmd(2, 100, 2, 1'b0); #1; chk("R5", 1, 100, 2, 0, 0);
        for (int i = 1; i < 4; i++) begin
            @(negedge clk); set_cmd(0); #1; chk("R5", 1, 100 + i, 2, 0, 0);
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); set_cmd(0); #1; chk("R7", 0, 0, 0, 0, 0);
        end

        // Back-to-back single-word WRITEs with AP to different banks (R5, R6)
        @(negedge clk); wr_cmd(0, 20, 0, 1'b1); #1; chk("R5", 1, 20, 0, 0, 0);
        @(negedge clk); wr_cmd(0, 21, 3, 1'b1); #1; chk("R6", 1, 21, 3, 1, 0);
        @(negedge clk); set_cmd(0); #1;          chk("R6", 0, 0, 0, 1, 3);
        @(negedge clk); #1;                      chk("R6", 0, 0, 0, 0, 0);

        // Terminate on a fixed burst with AP (R8, R7)
        @(negedge clk); wr_cmd(3, 40, 2, 1'b1); #1; chk("R1", 1, 40, 2, 0, 0);
        @(negedge clk); set_cmd(2); #1;            chk("R8", 0, 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); set_cmd(0); #1; chk("R7", 0, 0, 0, 0, 0);
        end

        // Clock suspend mid-burst, then a WRITE while suspended (R10)
        @(negedge clk); wr_cmd(2, 8, 3, 1'b1); #1; chk("R1", 1, 8, 3, 0, 0);
        @(negedge clk); set_cmd(0); cke = 0; #1;   chk("R10", 0, 0, 0, 0, 0);
        @(negedge clk); wr_cmd(0, 300, 1, 1'b0); #1; chk("R10", 0, 0, 0, 0, 0);
        @(negedge clk); set_cmd(0); cke = 1; #1;   chk("R10", 1, 9, 3, 0, 0);
        @(negedge clk); #1;                        chk("R10", 1, 10, 3, 0, 0);
        @(negedge clk); #1;                        chk("R10", 1, 11, 3, 0, 0);
        @(negedge clk); #1;                        chk("R6", 0, 0, 0, 1, 3);
        @(negedge clk); #1;                        chk("R3", 0, 0, 0, 0, 0);

        // Non-write patterns (R12)
        @(negedge clk); set_cmd(3); burst_mode = 3; addr = 12'd50; #1; chk("R12", 0, 0, 0, 0, 0);
        @(negedge clk); set_cmd(0); #1;                                 chk("R12", 0, 0, 0, 0, 0);
        @(negedge clk); set_cmd(4); #1;                                 chk("R12", 0, 0, 0, 0, 0);
        @(negedge clk); set_cmd(0); #1;                                 chk("R12", 0, 0, 0, 0, 0);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule